// File: doc/BRIEF.md
# Interrupt Request Latch with Per-Line Trigger Mode

This block captures interrupt requests from a bank of asynchronous input pins and holds them in a request vector until downstream acknowledge logic accepts them. Each input first crosses a short synchronizer chain. The synchronized level is then judged in one of two ways, chosen per line by a trigger-mode register. A level-sensitive line mirrors its input. An edge-sensitive line latches a request on a low-to-high transition and keeps it until that line is acknowledged.

A per-line shadow of the last synchronized level allows rising transitions to be detected. The trigger-mode register is loaded through a write port. The written value is filtered by a fixed per-instance mask, so lines that cannot support level triggering stay edge-sensitive. The stored value is always visible on an output.

Priority resolution and command decoding are handled by neighbouring logic. That logic reads the request vector and returns a single acknowledge, which names one line.

Top module: `irq_request_latch`

## Requirements
- R1: While `rst` is high at a rising clock edge, the request vector, the edge shadows, the synchronizer stages and the trigger-mode register are all cleared after that edge. Every line is therefore edge-triggered after reset.
- R2: A change on an input pin that is applied between clock edges reaches the request vector on the third rising edge that follows: two edges through the synchronizer and one through the request latch. It is not visible after only two edges.
- R3: Trigger-mode bit i set to 1 makes line i level-triggered, and set to 0 makes it edge-triggered.
- R4: On a level-triggered line, the request bit is 1 while the synchronized input is high and 0 while it is low.
- R5: On an edge-triggered line, a request is set only when the synchronized input is high and the shadow of its previous level is low. An input that stays high does not set the request again after it has been cleared.
- R6: On an edge-triggered line, a set request stays set after the input falls, until that line is acknowledged.
- R7: An acknowledge (`ack_valid` high, with `ack_line` giving the line index in binary) clears the request bit of that line on the next edge when the line is edge-triggered.
- R8: An acknowledge of a level-triggered line leaves its request bit unchanged.
- R9: A write (`mode_wr_en` high) loads `mode_wr_data` ANDed with the parameter `MODE_MASK` into the trigger-mode register on the next edge, and `trig_mode` shows the stored value. Mask bits at 0 force the matching line to edge mode.
- R10: When an edge-triggered line is set and acknowledged in the same cycle, the clear wins. The line then needs a new low-to-high transition of its input before it can be set again.
- R11: Lines are independent. Several requests can be pending together, and an acknowledge of one line leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pin | input | NUM_LINES (8) | Asynchronous interrupt input levels |
| ack_valid | input | 1 | Acknowledge strobe from the acceptance logic |
| ack_line | input | $clog2(NUM_LINES) (3) | Index of the acknowledged line |
| mode_wr_en | input | 1 | Write strobe for the trigger-mode register |
| mode_wr_data | input | NUM_LINES (8) | Trigger-mode write value, 1 = level, 0 = edge |
| req_vec | output | NUM_LINES (8) | Pending request vector |
| trig_mode | output | NUM_LINES (8) | Stored trigger-mode register |

## Verification
The bench builds the block with eight lines and a two-stage synchronizer, and sets `MODE_MASK` to 8'h7F. Because the top bit is masked, writing all ones reads back as 7F, and line 7 stays edge-triggered even after a write tries to make it level-sensitive. The two-stage chain makes the three-edge latency exact, so a check one edge early can tell it apart. Collisions are placed deliberately: an acknowledge is aimed at the very edge on which a rising input first reaches the latch, which shows that the clear wins and that the shadow then blocks any re-trigger.

// File: rtl/irq_req_pkg.sv
package irq_req_pkg;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_e;

    typedef struct packed {
        logic pend;
        logic last;
    } line_state_t;

    // Next state of one request line given the trigger kind, synchronized
    // input level and whether the line is being acknowledged this cycle.
    function automatic line_state_t line_next(
        input trig_e       kind,
        input logic        lvl,
        input logic        acked,
        input line_state_t cur
    );
        line_state_t nxt;
        nxt.last = lvl;
        if (kind == TRIG_LEVEL) begin
            nxt.pend = lvl;
        end else begin
            nxt.pend = cur.pend | (lvl & ~cur.last);
            if (acked) begin
                nxt.pend = 1'b0;
            end
        end
        return nxt;
    endfunction

endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            chain[0] <= '0;
        end else begin
            chain[0] <= async_in;
        end
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain[s] <= '0;
                end else begin
                    chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/irq_req_line.sv
module irq_req_line
    import irq_req_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  trig_e kind,
    input  logic  lvl,
    input  logic  acked,
    output logic  pend
);
    line_state_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= line_next(kind, lvl, acked, st_q);
        end
    end

    assign pend = st_q.pend;

    // R4: level line mirrors the synchronized input one edge later
    a_r4_level_follows: assert property (@(posedge clk) disable iff (rst)
        (kind == TRIG_LEVEL) |=> (pend == $past(lvl)));

    // R7 / R10: acknowledge of an edge line always clears it
    a_r7_ack_clears_edge: assert property (@(posedge clk) disable iff (rst)
        (kind == TRIG_EDGE && acked) |=> !pend);

    // R8: acknowledge does not disturb a level line held high
    a_r8_level_ack_ignored: assert property (@(posedge clk) disable iff (rst)
        (kind == TRIG_LEVEL && acked && lvl) |=> pend);

    // R6: pending edge request is sticky without an acknowledge
    a_r6_edge_sticky: assert property (@(posedge clk) disable iff (rst)
        (kind == TRIG_EDGE && pend && !acked) |=> pend);

    // R5: no edge request without a fresh rising level
    a_r5_no_spurious_set: assert property (@(posedge clk) disable iff (rst)
        (kind == TRIG_EDGE && !pend && !(lvl && !st_q.last)) |=> !pend);
endmodule

// File: rtl/irq_trig_mode_reg.sv
module irq_trig_mode_reg #(
    parameter int               WIDTH = 8,
    parameter logic [WIDTH-1:0] MASK  = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] mode
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= '0;
        end else if (wr_en) begin
            mode <= wr_data & MASK;
        end
    end

    // R9: a write lands masked on the next edge
    a_r9_masked_write: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (mode == ($past(wr_data) & MASK)));

    // R9: without a write the register holds
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(mode));
endmodule

// File: rtl/irq_request_latch.sv
module irq_request_latch
    import irq_req_pkg::*;
#(
    parameter int                   NUM_LINES   = 8,
    parameter int                   SYNC_STAGES = 2,
    parameter logic [NUM_LINES-1:0] MODE_MASK   = '1,
    localparam int                  IDX_W       = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] irq_pin,
    input  logic                 ack_valid,
    input  logic [IDX_W-1:0]     ack_line,
    input  logic                 mode_wr_en,
    input  logic [NUM_LINES-1:0] mode_wr_data,
    output logic [NUM_LINES-1:0] req_vec,
    output logic [NUM_LINES-1:0] trig_mode
);
    logic [NUM_LINES-1:0] lvl_sync;
    logic [NUM_LINES-1:0] ack_hit;

    irq_pin_sync #(
        .WIDTH  (NUM_LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (irq_pin),
        .sync_out (lvl_sync)
    );

    irq_trig_mode_reg #(
        .WIDTH (NUM_LINES),
        .MASK  (MODE_MASK)
    ) u_mode (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (mode_wr_en),
        .wr_data (mode_wr_data),
        .mode    (trig_mode)
    );

    generate
        for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
            assign ack_hit[i] = ack_valid && (ack_line == IDX_W'(i));

            irq_req_line u_line (
                .clk   (clk),
                .rst   (rst),
                .kind  (trig_e'(trig_mode[i])),
                .lvl   (lvl_sync[i]),
                .acked (ack_hit[i]),
                .pend  (req_vec[i])
            );
        end
    endgenerate

    // R1: reset leaves no pending request and every line edge-triggered
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (req_vec == '0 && trig_mode == '0));

    // R11: acknowledge never touches the other lines' pending bits
    a_r11_ack_isolated: assert property (@(posedge clk) disable iff (rst)
        ack_valid |-> $onehot0(ack_hit));
endmodule

// File: tb/tb_irq_request_latch.sv
`timescale 1ns/1ps
module tb_irq_request_latch;

    localparam int         N    = 8;
    localparam logic [7:0] MASK = 8'h7F;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] irq_pin = '0;
    logic       ack_valid = 1'b0;
    logic [2:0] ack_line = '0;
    logic       mode_wr_en = 1'b0;
    logic [7:0] mode_wr_data = '0;
    logic [7:0] req_vec;
    logic [7:0] trig_mode;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] exp_req;
        logic [7:0] exp_mode;
        string      tag;
    } exp_item_t;

    exp_item_t sb_q[$];

    always #10 clk = ~clk;

    irq_request_latch #(
        .NUM_LINES   (N),
        .SYNC_STAGES (2),
        .MODE_MASK   (MASK)
    ) dut (
        .clk          (clk),
        .rst          (rst),
        .irq_pin      (irq_pin),
        .ack_valid    (ack_valid),
        .ack_line     (ack_line),
        .mode_wr_en   (mode_wr_en),
        .mode_wr_data (mode_wr_data),
        .req_vec      (req_vec),
        .trig_mode    (trig_mode)
    );

    // Monitor: pop expected items and compare against the outputs
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            exp_item_t it;
            it = sb_q.pop_front();
            n_checks++;
            if (req_vec !== it.exp_req || trig_mode !== it.exp_mode) begin
                n_fail++;
                $display("FAIL %s: actual req=%02h mode=%02h expected req=%02h mode=%02h",
                         it.tag, req_vec, trig_mode, it.exp_req, it.exp_mode);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input logic [7:0] r, input logic [7:0] m, input string tag);
        exp_item_t it;
        it.exp_req  = r;
        it.exp_mode = m;
        it.tag      = tag;
        sb_q.push_back(it);
    endtask

    task automatic set_pins(input logic [7:0] v);
        @(negedge clk);
        irq_pin = v;
    endtask

    task automatic do_ack(input int line, input logic [7:0] r, input logic [7:0] m, input string tag);
        @(negedge clk);
        ack_valid = 1'b1;
        ack_line  = 3'(line);
        tick(1);
        expect_out(r, m, tag);
        @(negedge clk);
        ack_valid = 1'b0;
    endtask

    task automatic write_mode(input logic [7:0] v, input logic [7:0] r, input logic [7:0] m, input string tag);
        @(negedge clk);
        mode_wr_en   = 1'b1;
        mode_wr_data = v;
        tick(1);
        expect_out(r, m, tag);
        @(negedge clk);
        mode_wr_en = 1'b0;
    endtask

    initial begin : watchdog
        #(20 * 20000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : driver
        tick(3);
        expect_out(8'h00, 8'h00, "R1 reset state");
        @(negedge clk);
        rst = 1'b0;

        // Edge line 0: latency, stickiness, acknowledge
        set_pins(8'h01);
        tick(2);
        expect_out(8'h00, 8'h00, "R2 not visible after two edges");
        tick(1);
        expect_out(8'h01, 8'h00, "R2 visible on third edge, R3 edge default");
        set_pins(8'h00);
        tick(3);
        expect_out(8'h01, 8'h00, "R6 edge request sticky after fall");
        do_ack(0, 8'h00, 8'h00, "R7 ack clears edge line");

        // Edge line 1: held high does not retrigger
        set_pins(8'h02);
        tick(3);
        expect_out(8'h02, 8'h00, "R5 rising sets request");
        do_ack(1, 8'h00, 8'h00, "R7 ack clears line 1");
        tick(3);
        expect_out(8'h00, 8'h00, "R5 held-high input no retrigger");
        set_pins(8'h00);
        tick(3);
        set_pins(8'h02);
        tick(3);
        expect_out(8'h02, 8'h00, "R5 new rising edge sets again");
        do_ack(1, 8'h00, 8'h00, "R7 ack line 1 again");
        set_pins(8'h00);
        tick(3);

        // Trigger-mode write masking
        write_mode(8'hFF, 8'h00, 8'h7F, "R9 mask strips bit 7");
        write_mode(8'h04, 8'h00, 8'h04, "R9 readback of written value");

        // Level line 2
        set_pins(8'h04);
        tick(3);
        expect_out(8'h04, 8'h04, "R4 level line follows high");
        do_ack(2, 8'h04, 8'h04, "R8 ack ignored on level line");
        set_pins(8'h00);
        tick(3);
        expect_out(8'h00, 8'h04, "R4 level line follows low, R3");

        // Set and acknowledge in the same cycle on edge line 3
        set_pins(8'h08);
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        ack_valid = 1'b1;
        ack_line  = 3'd3;
        tick(1);
        expect_out(8'h00, 8'h04, "R10 clear wins over set");
        @(negedge clk);
        ack_valid = 1'b0;
        tick(3);
        expect_out(8'h00, 8'h04, "R10 no set without new edge");
        set_pins(8'h00);
        tick(3);
        set_pins(8'h08);
        tick(3);
        expect_out(8'h08, 8'h04, "R10 new edge sets after collision");
        do_ack(3, 8'h00, 8'h04, "R7 ack line 3");
        set_pins(8'h00);
        tick(3);

        // Masked bit 7 stays edge; independent lines
        write_mode(8'h80, 8'h00, 8'h00, "R9 masked level request dropped");
        set_pins(8'hE0);
        tick(3);
        expect_out(8'hE0, 8'h00, "R11 several lines pending together");
        do_ack(7, 8'h60, 8'h00, "R9 masked line 7 is edge, R11 others kept");
        set_pins(8'h00);
        tick(3);
        expect_out(8'h60, 8'h00, "R6 lines 5 and 6 held after fall");
        do_ack(5, 8'h40, 8'h00, "R11 ack line 5 only");
        do_ack(6, 8'h00, 8'h00, "R7 ack line 6");

        // Reset in mid-run
        write_mode(8'h03, 8'h00, 8'h03, "R9 write 03");
        set_pins(8'h01);
        tick(3);
        expect_out(8'h01, 8'h03, "R4 level line 0 high");
        @(negedge clk);
        rst = 1'b1;
        tick(1);
        expect_out(8'h00, 8'h00, "R1 reset clears request and mode");
        @(negedge clk);
        rst = 1'b0;
        tick(3);
        expect_out(8'h01, 8'h00, "R1 edge mode after reset, R2 latency");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule